// File: doc/BRIEF.md
# Round-Robin Active Channel Scanner

This block walks through the channels marked in a channel mask, naming one channel per enabled clock cycle, so one acquisition path can be shared in turn among all selected inputs. Channels whose mask bit is clear are never named. After the highest selected channel the walk returns to the lowest selected one and carries on without end. A sweep-start flag marks the cycles in which the named channel is the first one of a sweep.

The control is a two-state machine. `ST_ARM` is the state after reset, or after a cycle in which the mask was empty. On an enabled cycle it selects the lowest set mask bit, which can be channel 0. With a non-empty mask the transition *arm-to-scan* moves to `ST_SCAN`. With an empty mask the *arm-hold* transition stays in `ST_ARM`, with the index at 0. In `ST_SCAN` an enabled cycle takes the lowest set bit strictly above the current index, or the lowest set bit overall if there is none above (*scan-advance*). An enabled cycle with an empty mask clears the index and takes the *scan-to-arm* transition. A cycle with the enable low leaves state and index untouched (*hold*). Reset from either state is the *restart* transition to `ST_ARM`.

Top module: `chan_scanner`

## Requirements
- R1: A cycle with `rst` high sets `ch_sel` to 0 and arms the scan. The first enabled cycle after that selects the lowest set bit of `ch_mask`, including bit 0 when that bit is set.
- R2: Channels are selected in ascending index order, one per enabled cycle, and only channels whose mask bit is 1 are selected. Mask 16'hC6C6 yields 1, 2, 6, 7, 9, 10, 14, 15.
- R3: After the highest set channel, the next enabled cycle selects the lowest set channel, and the order repeats.
- R4: While `scan_en` is low, `ch_sel` keeps its value. When `scan_en` returns high, the scan continues from that channel.
- R5: `sweep_start` is 1 exactly when `ch_mask` is nonzero and `ch_sel` equals the index of its lowest set bit. The flag follows the present mask with no register delay.
- R6: With exactly one mask bit set, `ch_sel` stays on that channel on every enabled cycle and `sweep_start` stays 1.
- R7: With an all-zero mask, an enabled cycle sets `ch_sel` to 0 and `sweep_start` stays 0. The next enabled cycle with a nonzero mask selects its lowest set bit, including bit 0.
- R8: A mask change takes effect at the next enabled cycle. The scan then selects the lowest set bit of the new mask strictly above the current `ch_sel`, or the lowest set bit if there is none above, even when the current channel is no longer selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | Advance the scan on this cycle |
| ch_mask | input | NUM_CH (16) | One bit per channel, 1 = take part in the sweep |
| ch_sel | output | clog2(NUM_CH) (4) | Index of the currently selected channel |
| sweep_start | output | 1 | High while the selected channel is the lowest selected one |

## Verification
The bench builds the scanner with its default of 16 channels and a 4-bit index. At that size it can run the full eight-channel example sweep and the wrap from channel 15 down to channel 1. It can also check the two-channel masks whose bits lie at both ends of the index range, where a fault in the strictly-above search would appear. Channel 0 as the lowest set bit is covered after reset and after an empty mask, which is the case that needs the armed state.

// File: rtl/chan_scanner_pkg.sv
package chan_scanner_pkg;

    typedef enum logic [0:0] {
        ST_ARM  = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_t;

endpackage

// File: rtl/scan_lowest_set.sv
// Priority search: index of the lowest set bit of a vector.
module scan_lowest_set #(
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/scan_above_mask.sv
// Thermometer of the positions strictly above a given index.
module scan_above_mask #(
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [IDX_W-1:0] pos,
    output logic [WIDTH-1:0] above
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        assign above[g] = (g > int'(pos));
    end
endmodule

// File: rtl/chan_scanner.sv
module chan_scanner
    import chan_scanner_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic [NUM_CH-1:0] ch_mask,
    output logic [IDX_W-1:0]  ch_sel,
    output logic              sweep_start
);
    scan_state_t      state_q, state_n;
    logic [IDX_W-1:0] idx_q, idx_n;

    logic [NUM_CH-1:0] above_vec;
    logic              low_any, up_any;
    logic [IDX_W-1:0]  low_idx, up_idx;

    scan_above_mask #(.WIDTH(NUM_CH)) u_above (
        .pos   (idx_q),
        .above (above_vec)
    );

    scan_lowest_set #(.WIDTH(NUM_CH)) u_low (
        .vec   (ch_mask),
        .found (low_any),
        .idx   (low_idx)
    );

    scan_lowest_set #(.WIDTH(NUM_CH)) u_up (
        .vec   (ch_mask & above_vec),
        .found (up_any),
        .idx   (up_idx)
    );

    // transitions
    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        if (scan_en) begin
            unique case (state_q)
                ST_ARM: begin
                    if (low_any) begin
                        idx_n   = low_idx;
                        state_n = ST_SCAN;
                    end else begin
                        idx_n   = '0;
                    end
                end
                ST_SCAN: begin
                    if (!low_any) begin
                        idx_n   = '0;
                        state_n = ST_ARM;
                    end else if (up_any) begin
                        idx_n   = up_idx;
                    end else begin
                        idx_n   = low_idx;
                    end
                end
                default: begin
                    idx_n   = '0;
                    state_n = ST_ARM;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARM;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
        end
    end

    // outputs
    always_comb begin
        ch_sel      = idx_q;
        sweep_start = low_any && (idx_q == low_idx);
    end
endmodule

// File: rtl/chan_scanner_chk.sv
module chan_scanner_chk #(
    parameter int NUM_CH = 16,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst,
    input logic              scan_en,
    input logic [NUM_CH-1:0] ch_mask,
    input logic [IDX_W-1:0]  ch_sel,
    input logic              sweep_start
);
    logic [NUM_CH-1:0] mask_d;

    always_ff @(posedge clk) mask_d <= ch_mask;

    p_reset_zero_r1: assert property (@(posedge clk) rst |=> (ch_sel == '0));

    p_lands_on_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        (scan_en && (ch_mask != '0)) |=> mask_d[ch_sel]);

    p_hold_when_off_r4: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> $stable(ch_sel));

    p_flag_low_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (ch_mask == '0) |-> !sweep_start);

    p_single_stays_r6: assert property (@(posedge clk) disable iff (rst)
        (scan_en && ($countones(ch_mask) == 1)) |=>
            (sweep_start || (ch_mask != mask_d)));

    p_empty_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (scan_en && (ch_mask == '0)) |=> (ch_sel == '0));
endmodule

bind chan_scanner chan_scanner_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .scan_en     (scan_en),
    .ch_mask     (ch_mask),
    .ch_sel      (ch_sel),
    .sweep_start (sweep_start)
);

// File: tb/chan_scanner_test.sv
module chan_scanner_test;
    localparam int N  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scan_en = 1'b0;
    logic [N-1:0]  ch_mask = '0;
    logic [IW-1:0] ch_sel;
    logic          sweep_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    bit ref_armed = 1'b1;
    int ref_idx   = 0;

    int    q_sel[$];
    bit    q_flg[$];
    string q_tag[$];

    always #5 clk = ~clk;

    chan_scanner #(.NUM_CH(N)) uut (
        .clk         (clk),
        .rst         (rst),
        .scan_en     (scan_en),
        .ch_mask     (ch_mask),
        .ch_sel      (ch_sel),
        .sweep_start (sweep_start)
    );

    function automatic int lowest_of(logic [N-1:0] m);
        for (int i = 0; i < N; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic step(input bit r, input bit en, input logic [N-1:0] m, input string tag);
        @(negedge clk);
        rst     = r;
        scan_en = en;
        ch_mask = m;
        if (r) begin
            ref_armed = 1'b1;
            ref_idx   = 0;
        end else if (en) begin
            if (m == '0) begin
                ref_idx   = 0;
                ref_armed = 1'b1;
            end else if (ref_armed) begin
                ref_idx   = lowest_of(m);
                ref_armed = 1'b0;
            end else begin
                // circular search starting just past the current channel
                for (int k = 1; k <= N; k++) begin
                    if (m[(ref_idx + k) % N]) begin
                        ref_idx = (ref_idx + k) % N;
                        break;
                    end
                end
            end
        end
        q_sel.push_back(ref_idx);
        q_flg.push_back((m != '0) && (ref_idx == lowest_of(m)));
        q_tag.push_back(tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_sel.size() > 0) begin
                int    es;
                bit    ef;
                string et;
                es = q_sel.pop_front();
                ef = q_flg.pop_front();
                et = q_tag.pop_front();
                checks++;
                if ((int'(ch_sel) != es) || (sweep_start != ef)) begin
                    fails++;
                    $display("FAIL %s: sel=%0d flag=%0b expected sel=%0d flag=%0b",
                             et, ch_sel, sweep_start, es, ef);
                end
            end
        end
    end

    // watchdog
    initial begin
        #200us;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1, 1, 16'hC6C6, "R1");
        step(1, 0, 16'hC6C6, "R1");
        // R2 ascending sweep, R5 flag on channel 1
        for (int i = 0; i < 8; i++) step(0, 1, 16'hC6C6, "R2");
        // R3 wrap and repeat
        for (int i = 0; i < 4; i++) step(0, 1, 16'hC6C6, "R3");
        // R4 hold and resume
        for (int i = 0; i < 3; i++) step(0, 0, 16'hC6C6, "R4");
        for (int i = 0; i < 3; i++) step(0, 1, 16'hC6C6, "R4");
        // R1 restart mid sweep, with channel 0 set
        step(1, 1, 16'h0031, "R1");
        step(0, 1, 16'h0031, "R1");
        step(0, 1, 16'h0031, "R5");
        // R6 single channel
        for (int i = 0; i < 4; i++) step(0, 1, 16'h0001, "R6");
        step(0, 1, 16'h0040, "R6");
        step(0, 1, 16'h0040, "R6");
        // R8 two channels, bits 0 and 3
        for (int i = 0; i < 4; i++) step(0, 1, 16'h0009, "R8");
        // R8 far apart, bits 1 and 15, with R3 wrap
        for (int i = 0; i < 4; i++) step(0, 1, 16'h8002, "R3");
        // R5 flag follows mask without advancing
        step(0, 0, 16'h8000, "R5");
        step(0, 0, 16'h8002, "R5");
        // R7 empty mask, then channel 0
        for (int i = 0; i < 3; i++) step(0, 1, 16'h0000, "R7");
        step(0, 0, 16'h0000, "R7");
        step(0, 1, 16'h0001, "R7");
        step(0, 1, 16'h0005, "R7");
        // R8 current channel dropped from mask
        step(1, 0, 16'hC6C6, "R1");
        for (int i = 0; i < 5; i++) step(0, 1, 16'hC6C6, "R8");
        step(0, 1, 16'h0300, "R8");
        step(0, 1, 16'h0300, "R8");
        step(0, 1, 16'h0300, "R8");
        step(0, 1, 16'h0204, "R8");
        // drain
        while (q_sel.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule